// File: doc/BRIEF.md
# Physical Register Rename Unit

This unit renames architectural register names into physical register tags for an out-of-order core that keeps every value, speculative or committed, in a single merged physical register file. It holds 32 logical registers and 64 physical registers. Two map tables track them: a speculative map that decode uses to translate names, and a committed map that reflects retired state. Physical tags that are not in use sit in a free list.

When an instruction is renamed, its two sources are looked up in the speculative map. Its destination gets the tag at the head of the free list. The tag that destination held before is reported so that the reorder buffer can keep it. Retirement moves only a mapping: the committed map takes the new tag, and the tag it replaces goes back to the free list. No data is copied. A recovery pulse makes the speculative map a copy of the committed map and refills the free list from the tags that the committed map does not reference.

Top module: `rn_rename_unit`

## Requirements
- R1: After reset, logical register n maps to physical tag n in both maps, and the free list holds tags 32 to 63, so the first allocations return 32, 33, 34 and onward in that order.
- R2: A rename with `ren_valid` high and `ren_stall` low returns the head of the free list as `ren_pdst` in the same cycle and removes it. Tags leave the free list in first-in, first-out order.
- R3: After a rename of destination d, a later rename that reads d as a source gets that instruction's `ren_pdst`. A source that names the destination of the same instruction gets the mapping from before that instruction.
- R4: `ren_pold` shows the speculative mapping that the destination held just before the rename.
- R5: `ren_stall` is high while the free list is empty. This happens after 32 renames with no commit in between.
- R6: A rename presented while `ren_stall` is high changes neither map nor the free list.
- R7: A commit with `cmt_valid` high sets the committed mapping of `cmt_ldst` to `cmt_pdst`, and appends the tag it replaces to the tail of the free list. No tag is freed in any other way.
- R8: While `recover` is high, `ren_stall` is high and renames are ignored. On the next cycle the speculative map equals the committed map, including any commit presented in the recovery cycle.
- R9: After recovery, the free list holds exactly the physical tags that the committed map does not reference, handed out in ascending order.
- R10: Logical register 0 is renamed like every other register. It has no fixed zero mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Rename request |
| ren_src1 | input | 5 | First source logical register |
| ren_src2 | input | 5 | Second source logical register |
| ren_dst | input | 5 | Destination logical register |
| ren_psrc1 | output | 6 | Physical tag of first source |
| ren_psrc2 | output | 6 | Physical tag of second source |
| ren_pdst | output | 6 | Newly allocated destination tag |
| ren_pold | output | 6 | Previous speculative tag of the destination |
| ren_stall | output | 1 | Rename cannot proceed this cycle |
| cmt_valid | input | 1 | Retire one instruction's mapping |
| cmt_ldst | input | 5 | Logical destination being retired |
| cmt_pdst | input | 6 | Physical tag that becomes committed |
| recover | input | 1 | Restore speculative state from committed state |

## Verification
Renames go back to back through chains that read a destination just written, through sources that equal their own destination, and through register 0. These separate the pre-update lookup from forwarding of the new tag. The free list is drained until the unit stalls, and renames are then offered during the stall, to show that stalled requests leave no trace. Commits are issued alone and in the same cycle as renames, so the order in which freed tags come back out shows the FIFO discipline. Recovery is tried both with and without a commit in the same cycle. The tags allocated after each recovery tell an ascending rebuild apart from a stale free list.

// File: rtl/rn_pkg.sv
package rn_pkg;
  parameter int unsigned LOG_REGS  = 32;
  parameter int unsigned PHYS_REGS = 64;

  localparam int unsigned LTAG_W     = $clog2(LOG_REGS);
  localparam int unsigned PTAG_W     = $clog2(PHYS_REGS);
  localparam int unsigned SPARE_REGS = PHYS_REGS - LOG_REGS;
  localparam int unsigned CNT_W      = $clog2(SPARE_REGS + 1);

  typedef logic [LTAG_W-1:0] ltag_t;
  typedef logic [PTAG_W-1:0] ptag_t;
endpackage

// File: rtl/rn_spec_map.sv
module rn_spec_map
  import rn_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  ltag_t                rd_a1,
  input  ltag_t                rd_a2,
  input  ltag_t                rd_a3,
  output ptag_t                rd_p1,
  output ptag_t                rd_p2,
  output ptag_t                rd_p3,
  input  logic                 wr_en,
  input  ltag_t                wr_ltag,
  input  ptag_t                wr_ptag,
  input  logic                 restore_en,
  input  ptag_t [LOG_REGS-1:0] restore_map
);
  ptag_t [LOG_REGS-1:0] map_q, map_d;
  logic                 map_upd;

  // reads see the table before this cycle's update
  assign rd_p1 = map_q[rd_a1];
  assign rd_p2 = map_q[rd_a2];
  assign rd_p3 = map_q[rd_a3];

  assign map_upd = wr_en | restore_en;

  always_comb begin
    map_d = map_q;
    if (restore_en) begin
      map_d = restore_map;
    end else if (wr_en) begin
      map_d[wr_ltag] = wr_ptag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LOG_REGS; i++) map_q[i] <= ptag_t'(i);
    end else if (map_upd) begin
      map_q <= map_d;
    end
  end
endmodule

// File: rtl/rn_commit_map.sv
module rn_commit_map
  import rn_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmt_en,
  input  ltag_t                cmt_ltag,
  input  ptag_t                cmt_ptag,
  output ptag_t                freed_ptag,
  output ptag_t [LOG_REGS-1:0] map_next
);
  ptag_t [LOG_REGS-1:0] map_q;

  assign freed_ptag = map_q[cmt_ltag];

  always_comb begin
    map_next = map_q;
    if (cmt_en) map_next[cmt_ltag] = cmt_ptag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LOG_REGS; i++) map_q[i] <= ptag_t'(i);
    end else if (cmt_en) begin
      map_q <= map_next;
    end
  end
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list
  import rn_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pop_en,
  input  logic                 push_en,
  input  ptag_t                push_tag,
  input  logic                 rebuild_en,
  input  ptag_t [LOG_REGS-1:0] rebuild_map,
  output ptag_t                head_tag,
  output logic                 empty,
  output logic [CNT_W-1:0]     count
);
  localparam int unsigned      PTR_W    = (SPARE_REGS > 1) ? $clog2(SPARE_REGS) : 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(SPARE_REGS);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(SPARE_REGS - 1);

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  ptag_t [SPARE_REGS-1:0] slots_q, slots_d;
  logic  [PTR_W-1:0]      head_q, head_d, tail_q, tail_d;
  logic  [CNT_W-1:0]      count_q, count_d;
  logic                   fl_upd;

  // rebuild: mark referenced tags, then pack the rest in ascending order
  logic [PHYS_REGS-1:0]   used;
  ptag_t [SPARE_REGS-1:0] scan_tags;
  logic  [CNT_W-1:0]      scan_cnt;

  always_comb begin
    used = '0;
    for (int i = 0; i < LOG_REGS; i++) used[rebuild_map[i]] = 1'b1;
  end

  always_comb begin
    scan_tags = '0;
    scan_cnt  = '0;
    for (int p = 0; p < PHYS_REGS; p++) begin
      if (!used[p] && (scan_cnt < FULL_CNT)) begin
        scan_tags[scan_cnt[PTR_W-1:0]] = ptag_t'(p);
        scan_cnt = scan_cnt + CNT_W'(1);
      end
    end
  end

  assign head_tag = slots_q[head_q];
  assign empty    = (count_q == '0);
  assign count    = count_q;
  assign fl_upd   = rebuild_en | pop_en | push_en;

  always_comb begin
    slots_d = slots_q;
    head_d  = head_q;
    tail_d  = tail_q;
    count_d = count_q;
    if (rebuild_en) begin
      slots_d = scan_tags;
      head_d  = '0;
      tail_d  = (scan_cnt == FULL_CNT) ? '0 : scan_cnt[PTR_W-1:0];
      count_d = scan_cnt;
    end else begin
      if (pop_en) head_d = ptr_inc(head_q);
      if (push_en) begin
        slots_d[tail_q] = push_tag;
        tail_d          = ptr_inc(tail_q);
      end
      case ({push_en, pop_en})
        2'b10:   count_d = count_q + CNT_W'(1);
        2'b01:   count_d = count_q - CNT_W'(1);
        default: count_d = count_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SPARE_REGS; i++) slots_q[i] <= ptag_t'(LOG_REGS + i);
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= FULL_CNT;
    end else if (fl_upd) begin
      slots_q <= slots_d;
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
    end
  end
endmodule

// File: rtl/rn_rename_unit.sv
module rn_rename_unit
  import rn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ren_valid,
  input  logic [LTAG_W-1:0] ren_src1,
  input  logic [LTAG_W-1:0] ren_src2,
  input  logic [LTAG_W-1:0] ren_dst,
  output logic [PTAG_W-1:0] ren_psrc1,
  output logic [PTAG_W-1:0] ren_psrc2,
  output logic [PTAG_W-1:0] ren_pdst,
  output logic [PTAG_W-1:0] ren_pold,
  output logic              ren_stall,
  input  logic              cmt_valid,
  input  logic [LTAG_W-1:0] cmt_ldst,
  input  logic [PTAG_W-1:0] cmt_pdst,
  input  logic              recover
);
  logic                 ren_fire;
  logic                 fl_empty;
  logic [CNT_W-1:0]     free_count;
  ptag_t                head_tag;
  ptag_t                freed_tag;
  ptag_t [LOG_REGS-1:0] cmt_map_next;

  assign ren_stall = fl_empty | recover;
  assign ren_fire  = ren_valid & ~ren_stall;
  assign ren_pdst  = head_tag;

  rn_spec_map u_spec (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_a1       (ren_src1),
    .rd_a2       (ren_src2),
    .rd_a3       (ren_dst),
    .rd_p1       (ren_psrc1),
    .rd_p2       (ren_psrc2),
    .rd_p3       (ren_pold),
    .wr_en       (ren_fire),
    .wr_ltag     (ren_dst),
    .wr_ptag     (head_tag),
    .restore_en  (recover),
    .restore_map (cmt_map_next)
  );

  rn_commit_map u_cmt (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmt_en     (cmt_valid),
    .cmt_ltag   (cmt_ldst),
    .cmt_ptag   (cmt_pdst),
    .freed_ptag (freed_tag),
    .map_next   (cmt_map_next)
  );

  rn_free_list u_free (
    .clk         (clk),
    .rst_n       (rst_n),
    .pop_en      (ren_fire),
    .push_en     (cmt_valid),
    .push_tag    (freed_tag),
    .rebuild_en  (recover),
    .rebuild_map (cmt_map_next),
    .head_tag    (head_tag),
    .empty       (fl_empty),
    .count       (free_count)
  );
endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk
  import rn_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ren_valid,
  input logic [LTAG_W-1:0] ren_src1,
  input logic [LTAG_W-1:0] ren_dst,
  input logic [PTAG_W-1:0] ren_psrc1,
  input logic [PTAG_W-1:0] ren_pdst,
  input logic [PTAG_W-1:0] ren_pold,
  input logic              ren_stall,
  input logic              cmt_valid,
  input logic              recover,
  input logic [CNT_W-1:0]  fl_count
);
  logic fire;
  assign fire = ren_valid && !ren_stall;

  // R2
  alloc_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !cmt_valid |=> fl_count == $past(fl_count) - 1);

  // R3
  new_tag_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && $past(fire) && ren_src1 == $past(ren_dst) |-> ren_psrc1 == $past(ren_pdst));

  // R4
  fresh_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ren_pdst != ren_pold);

  // R7
  free_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_count <= CNT_W'(SPARE_REGS));

  // R7
  release_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid && !recover && !fire |=> fl_count == $past(fl_count) + 1);

  // R9
  rebuild_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recover |=> fl_count == CNT_W'(SPARE_REGS));
endmodule

bind rn_rename_unit rn_rename_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ren_valid (ren_valid),
  .ren_src1  (ren_src1),
  .ren_dst   (ren_dst),
  .ren_psrc1 (ren_psrc1),
  .ren_pdst  (ren_pdst),
  .ren_pold  (ren_pold),
  .ren_stall (ren_stall),
  .cmt_valid (cmt_valid),
  .recover   (recover),
  .fl_count  (free_count)
);

// File: tb/rn_rename_unit_bench.sv
`timescale 1ns/1ps
module rn_rename_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ren_valid = 1'b0;
  logic [4:0] ren_src1 = '0, ren_src2 = '0, ren_dst = '0;
  logic [5:0] ren_psrc1, ren_psrc2, ren_pdst, ren_pold;
  logic       ren_stall;
  logic       cmt_valid = 1'b0;
  logic [4:0] cmt_ldst = '0;
  logic [5:0] cmt_pdst = '0;
  logic       recover = 1'b0;

  always #2 clk = ~clk;

  rn_rename_unit u_rn_rename_unit (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_src1(ren_src1),
    .ren_src2(ren_src2), .ren_dst(ren_dst), .ren_psrc1(ren_psrc1),
    .ren_psrc2(ren_psrc2), .ren_pdst(ren_pdst), .ren_pold(ren_pold),
    .ren_stall(ren_stall), .cmt_valid(cmt_valid), .cmt_ldst(cmt_ldst),
    .cmt_pdst(cmt_pdst), .recover(recover)
  );

  typedef struct {
    int    stall;
    int    p1, p2, pd, po;
    string req;
  } exp_t;

  exp_t  expq[$];
  int    spec_m[32];
  int    cmt_m[32];
  int    freeq[$];
  int    infl_l[$];
  int    infl_p[$];
  int    tests = 0;
  int    fails = 0;
  bit    done = 1'b0;
  event  mon_ev;

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops the expected item for this cycle and compares
  initial forever begin
    @(mon_ev);
    if (expq.size() > 0) begin
      exp_t e;
      e = expq.pop_front();
      check(e.req, "stall", int'(ren_stall), e.stall);
      if (e.stall == 0) begin
        check(e.req, "psrc1", int'(ren_psrc1), e.p1);
        check(e.req, "psrc2", int'(ren_psrc2), e.p2);
        check(e.req, "pdst",  int'(ren_pdst),  e.pd);
        check(e.req, "pold",  int'(ren_pold),  e.po);
      end
    end
  end

  // driver: one cycle of stimulus, expectation pushed before the monitor samples
  task automatic do_cycle(input bit rv, input int s1, input int s2, input int d,
                          input bit cv, input string req, input bit rec);
    exp_t e;
    bit   cmt_go;
    int   cl, cp;
    @(negedge clk);
    cmt_go = cv && (infl_l.size() > 0);
    cl = 0; cp = 0;
    if (cmt_go) begin
      cl = infl_l.pop_front();
      cp = infl_p.pop_front();
    end
    ren_valid = rv;
    ren_src1  = s1[4:0];
    ren_src2  = s2[4:0];
    ren_dst   = d[4:0];
    cmt_valid = cmt_go;
    cmt_ldst  = cl[4:0];
    cmt_pdst  = cp[5:0];
    recover   = rec;
    e.stall = (rec || freeq.size() == 0) ? 1 : 0;
    e.p1 = spec_m[s1];
    e.p2 = spec_m[s2];
    e.pd = (e.stall == 0) ? freeq[0] : 0;
    e.po = spec_m[d];
    e.req = req;
    if (rv) expq.push_back(e);
    #1;
    ->mon_ev;
    #0.1;
    if (rv && e.stall == 0) begin
      int pd;
      pd = freeq.pop_front();
      spec_m[d] = pd;
      infl_l.push_back(d);
      infl_p.push_back(pd);
    end
    if (cmt_go) begin
      freeq.push_back(cmt_m[cl]);
      cmt_m[cl] = cp;
    end
    if (rec) begin
      bit refd[64];
      for (int p = 0; p < 64; p++) refd[p] = 1'b0;
      for (int i = 0; i < 32; i++) begin
        spec_m[i] = cmt_m[i];
        refd[cmt_m[i]] = 1'b1;
      end
      freeq.delete();
      for (int p = 0; p < 64; p++) if (!refd[p]) freeq.push_back(p);
      infl_l.delete();
      infl_p.delete();
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      spec_m[i] = i;
      cmt_m[i]  = i;
      freeq.push_back(32 + i);
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: out of reset, free list non-empty so no stall
    check("R1", "reset stall", int'(ren_stall), 0);

    do_cycle(1, 1, 2, 3, 0, "R1", 0);
    do_cycle(1, 3, 4, 3, 0, "R3", 0);
    do_cycle(1, 3, 3, 3, 0, "R3", 0);
    do_cycle(1, 0, 0, 0, 0, "R10", 0);
    do_cycle(1, 0, 31, 31, 0, "R4", 0);
    do_cycle(1, 31, 0, 0, 0, "R10", 0);
    // drain the free list
    for (int n = 0; freeq.size() > 0; n++)
      do_cycle(1, (n * 5) % 32, (n * 3) % 32, (n * 7) % 32, 0, "R2", 0);
    do_cycle(1, 5, 6, 9, 0, "R5", 0);
    do_cycle(1, 9, 9, 9, 0, "R6", 0);
    do_cycle(1, 9, 1, 2, 1, "R5", 0);
    // commits alone, then freed tags come back in order
    for (int k = 0; k < 4; k++) do_cycle(0, 0, 0, 0, 1, "R7", 0);
    do_cycle(1, 9, 3, 12, 0, "R6", 0);
    do_cycle(1, 12, 1, 13, 1, "R7", 0);
    for (int k = 0; k < 6; k++) do_cycle(1, k, 12, 20 + k, 1, "R7", 0);
    // recovery with a commit in the same cycle
    do_cycle(1, 1, 2, 3, 1, "R8", 1);
    do_cycle(1, 3, 0, 5, 0, "R8", 0);
    do_cycle(1, 5, 12, 6, 0, "R9", 0);
    do_cycle(1, 6, 3, 0, 0, "R9", 0);
    for (int k = 0; k < 5; k++) do_cycle(1, k + 8, 0, k + 8, (k % 2) == 1, "R7", 0);
    // recovery without commit
    do_cycle(0, 0, 0, 0, 0, "R8", 1);
    do_cycle(1, 8, 9, 10, 0, "R8", 0);
    for (int k = 0; k < 4; k++) do_cycle(1, k, k + 1, 31 - k, 0, "R9", 0);
    @(negedge clk);
    ren_valid = 1'b0;
    cmt_valid = 1'b0;
    recover   = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule